// File: doc/BRIEF.md
# Fractional-Rate Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port with 8-bit characters. Its bit timing does not come from an integer clock divider. A single rate word is added every clock into a 16-bit phase accumulator, and each overflow of that accumulator closes one bit period. With the intended 16 MHz clock, one unit of the word is worth about 244.14 baud, so the configured rate is the rate word divided by 0.004096. This covers roughly 9600 baud up to 3 Mbaud with fine granularity. The transmitter and the receiver each own an accumulator. The receiver does not oversample the line. When it sees a start edge it pre-loads its accumulator to half scale, so that later overflows fall near the centre of each bit.

The host side uses two byte-wide valid/ready handshakes, one for transmit and one for receive. The receive side has a single holding register. Static configuration inputs select the rate word, the parity mode, one or two stop bits, and whether hardware flow control is active. On the line side there are the serial data pins and two active-low flow-control pins. The request pin tells the far end whether this side can take a byte. The clear pin from the far end gates when a new character may begin. Each received byte is delivered together with a parity-error flag and a framing-error flag.

Top module: `uart_frac_top`

## Requirements
- R1: The clock counts of all bit periods are set by a 16-bit accumulator. It is cleared when a character starts and advanced by `rate_word` every clock. Bit n (the start bit is n=0) ends ceil((n+1)*65536/rate_word) clocks after the start bit begins.
- R2: `txd` idles high. A character on `txd` is sent in this order: a low start bit, the 8 data bits least-significant first, an optional parity bit, then the stop bits, which are high.
- R3: `parity_mode` encoding: 2'b00 means no parity bit. 2'b01 means odd parity, so data plus parity holds an odd count of ones. 2'b10 means even parity. 2'b11 behaves as no parity.
- R4: `stop_two`=0 sends one stop bit and `stop_two`=1 sends two. With `tx_valid` held high, the next start bit begins between F and F+1 clocks after the previous one, where F is the R1 end of the last stop bit.
- R5: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. `txd` is low from the following clock on. `tx_ready` stays low until the character ends.
- R6: With `flow_en`=1 and `cts_n` high for at least two clocks, `tx_ready` is low and no character starts. With `flow_en`=0, `cts_n` has no effect.
- R7: A character received on `rxd` at the same rate word is presented on `rx_data` with `rx_valid` high. It stays there until a clock with `rx_ready` high, and `rx_valid` is low from the next clock.
- R8: A low pulse on `rxd` that ends before the centre of a start bit delivers no byte. The receiver then accepts the next proper character.
- R9: `rx_ferr` is 1 when the first stop bit is sampled low, and 0 otherwise.
- R10: `rx_perr` is 1 when parity is enabled and the received parity bit does not match the R3 rule for the received data. It is 0 when parity is off or matches.
- R11: With `flow_en`=1, `rts_n` is low while the holding register is empty and high while a byte waits unread. With `flow_en`=0, `rts_n` is low.
- R12: After reset, `txd` is high, `rx_valid` is low, `rts_n` is low, and with `flow_en`=0 `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, nominally 16 MHz |
| rst | input | 1 | Synchronous active-high reset |
| rate_word | input | 16 | Accumulator step; baud = rate_word / 0.004096 |
| parity_mode | input | 2 | 00 none, 01 odd, 10 even, 11 none |
| stop_two | input | 1 | 1 selects two stop bits |
| flow_en | input | 1 | Enables request/clear flow control |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter can accept a byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Holding register full |
| rx_ready | input | 1 | Host consumes the held byte |
| rx_perr | output | 1 | Parity error for the held byte |
| rx_ferr | output | 1 | Framing error for the held byte |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line, idles high |
| rts_n | output | 1 | Request to send, active low |
| cts_n | input | 1 | Clear to send, active low |

## Verification
The bench computes every bit boundary from the ceiling formula. It samples `txd` mid-bit at three rate words, one of them not a power of two. A design that drifted or rounded the fractional phase would therefore misplace later bits. The same frames are looped into the receiver across all parity and stop settings, and every byte value is swept at one setting. This catches wrong bit order, wrong parity polarity, a missing second stop bit (exposed by back-to-back start spacing), and a receiver that sampled off-centre. Hand-built receive frames with a low stop bit, a wrong parity bit, and a one-clock glitch target the error flags and the false-start rejection. A design that skipped the start-centre check would deliver a spurious byte. Flow control is exercised by holding the clear input high: a transmitter that ignored it would drive a start bit during the blocked window.

// File: rtl/uart_frac_pkg.sv
`timescale 1ns/1ps
package uart_frac_pkg;

    localparam int DATA_BITS = 8;
    localparam int FRAME_MAX = DATA_BITS + 4;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);
    localparam int IDX_W     = $clog2(DATA_BITS);

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ODD  = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_RSVD = 2'b11
    } parity_e;

    typedef struct packed {
        parity_e par;
        logic    stop_two;
    } frame_cfg_t;

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 perr;
        logic                 ferr;
    } rx_char_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    function automatic logic has_parity(parity_e p);
        return (p == PAR_ODD) || (p == PAR_EVEN);
    endfunction

    function automatic logic parity_bit(logic [DATA_BITS-1:0] d, parity_e p);
        return (p == PAR_ODD) ? ~(^d) : (^d);
    endfunction

    function automatic logic [CNT_W-1:0] frame_bits(frame_cfg_t c);
        logic [CNT_W-1:0] n;
        n = CNT_W'(DATA_BITS + 2);
        if (has_parity(c.par)) n = n + 1'b1;
        if (c.stop_two)        n = n + 1'b1;
        return n;
    endfunction

    function automatic logic [FRAME_MAX-1:0] build_frame(logic [DATA_BITS-1:0] d, frame_cfg_t c);
        logic [FRAME_MAX-1:0] f;
        f = '1;
        f[0] = 1'b0;
        f[DATA_BITS:1] = d;
        if (has_parity(c.par)) f[DATA_BITS+1] = parity_bit(d, c.par);
        return f;
    endfunction

endpackage

// File: rtl/bit_sync.sv
`timescale 1ns/1ps
module bit_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/frac_baud_gen.sv
`timescale 1ns/1ps
module frac_baud_gen #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             preset_half,
    input  logic [ACC_W-1:0] step,
    output logic             tick
);
    localparam logic [ACC_W-1:0] HALF = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   sum;

    always_comb begin
        sum  = {1'b0, acc} + {1'b0, step};
        tick = sum[ACC_W];
    end

    always_ff @(posedge clk) begin
        if (rst)              acc <= '0;
        else if (clear)       acc <= '0;
        else if (preset_half) acc <= HALF;
        else                  acc <= sum[ACC_W-1:0];
    end
endmodule

// File: rtl/uart_tx_core.sv
`timescale 1ns/1ps
module uart_tx_core
    import uart_frac_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ACC_W-1:0]     rate,
    input  frame_cfg_t           cfg,
    input  logic                 hold_off,
    input  logic [DATA_BITS-1:0] din,
    input  logic                 din_valid,
    output logic                 din_ready,
    output logic                 txd
);
    logic                 busy;
    logic                 tick;
    logic                 accept;
    logic [FRAME_MAX-1:0] frm;
    logic [FRAME_MAX-1:0] sh;
    logic [CNT_W-1:0]     left;

    assign din_ready = !busy && !hold_off;
    assign accept    = din_valid && din_ready;

    always_comb frm = build_frame(din, cfg);

    frac_baud_gen #(.ACC_W(ACC_W)) u_gen (
        .clk         (clk),
        .rst         (rst),
        .clear       (accept),
        .preset_half (1'b0),
        .step        (rate),
        .tick        (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sh   <= '1;
            left <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            sh   <= frm;
            left <= frame_bits(cfg) - CNT_W'(1);
        end else if (busy && tick) begin
            if (left == '0) begin
                busy <= 1'b0;
                sh   <= '1;
            end else begin
                sh   <= {1'b1, sh[FRAME_MAX-1:1]};
                left <= left - 1'b1;
            end
        end
    end

    assign txd = sh[0];
endmodule

// File: rtl/uart_rx_core.sv
`timescale 1ns/1ps
module uart_rx_core
    import uart_frac_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] rate,
    input  parity_e          par,
    input  logic             rxs,
    output logic             got,
    output rx_char_t         ch
);
    rx_state_e            state;
    parity_e              par_q;
    logic                 rxs_d;
    logic                 fall;
    logic                 tick;
    logic [DATA_BITS-1:0] sh;
    logic [IDX_W-1:0]     idx;
    logic                 perr_q;

    assign fall = (state == RX_IDLE) && rxs_d && !rxs;

    frac_baud_gen #(.ACC_W(ACC_W)) u_gen (
        .clk         (clk),
        .rst         (rst),
        .clear       (1'b0),
        .preset_half (fall),
        .step        (rate),
        .tick        (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) rxs_d <= 1'b1;
        else     rxs_d <= rxs;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_IDLE;
            par_q  <= PAR_NONE;
            sh     <= '0;
            idx    <= '0;
            perr_q <= 1'b0;
            got    <= 1'b0;
            ch     <= '0;
        end else begin
            got <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (fall) begin
                        state  <= RX_START;
                        par_q  <= par;
                        perr_q <= 1'b0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        idx   <= '0;
                        state <= rxs ? RX_IDLE : RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        sh <= {rxs, sh[DATA_BITS-1:1]};
                        if (idx == IDX_W'(DATA_BITS - 1))
                            state <= has_parity(par_q) ? RX_PAR : RX_STOP;
                        else
                            idx <= idx + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (tick) begin
                        perr_q <= (parity_bit(sh, par_q) != rxs);
                        state  <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        got     <= 1'b1;
                        ch.data <= sh;
                        ch.perr <= perr_q;
                        ch.ferr <= !rxs;
                        state   <= RX_IDLE;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_frac_top.sv
`timescale 1ns/1ps
module uart_frac_top
    import uart_frac_pkg::*;
#(
    parameter int ACC_W     = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] rate_word,
    input  logic [1:0]       parity_mode,
    input  logic             stop_two,
    input  logic             flow_en,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    input  logic             rx_ready,
    output logic             rx_perr,
    output logic             rx_ferr,
    output logic             txd,
    input  logic             rxd,
    output logic             rts_n,
    input  logic             cts_n
);
    frame_cfg_t cfg;
    logic       cts_s;
    logic       rxs;
    logic       got;
    rx_char_t   ch;
    rx_char_t   held;
    logic       full;

    always_comb begin
        cfg.par      = parity_e'(parity_mode);
        cfg.stop_two = stop_two;
    end

    bit_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_cts_sync (
        .clk (clk), .rst (rst), .d (cts_n), .q (cts_s)
    );

    bit_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_rxd_sync (
        .clk (clk), .rst (rst), .d (rxd), .q (rxs)
    );

    uart_tx_core #(.ACC_W(ACC_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .rate      (rate_word),
        .cfg       (cfg),
        .hold_off  (flow_en && cts_s),
        .din       (tx_data),
        .din_valid (tx_valid),
        .din_ready (tx_ready),
        .txd       (txd)
    );

    uart_rx_core #(.ACC_W(ACC_W)) u_rx (
        .clk  (clk),
        .rst  (rst),
        .rate (rate_word),
        .par  (cfg.par),
        .rxs  (rxs),
        .got  (got),
        .ch   (ch)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            held <= '0;
        end else if (got) begin
            full <= 1'b1;
            held <= ch;
        end else if (full && rx_ready) begin
            full <= 1'b0;
        end
    end

    assign rx_valid = full;
    assign rx_data  = held.data;
    assign rx_perr  = held.perr;
    assign rx_ferr  = held.ferr;
    assign rts_n    = flow_en ? full : 1'b0;
endmodule

// File: rtl/uart_frac_checker.sv
`timescale 1ns/1ps
module uart_frac_checker (
    input logic clk,
    input logic rst,
    input logic tx_valid,
    input logic tx_ready,
    input logic txd,
    input logic cts_n,
    input logic flow_en,
    input logic rx_valid,
    input logic rx_ready,
    input logic rts_n
);
    assert_start_after_accept_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !txd);

    assert_idle_line_high_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && !tx_valid) |=> txd);

    assert_cts_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        (flow_en && $past(flow_en) && cts_n && $past(cts_n) && $past(cts_n, 2)) |-> !tx_ready);

    assert_hold_until_read_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> rx_valid);

    assert_rts_empty_R11: assert property (@(posedge clk) disable iff (rst)
        (flow_en && !rts_n) |-> !rx_valid);

    assert_rts_off_R11: assert property (@(posedge clk) disable iff (rst)
        !flow_en |-> !rts_n);
endmodule

bind uart_frac_top uart_frac_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .txd      (txd),
    .cts_n    (cts_n),
    .flow_en  (flow_en),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rts_n    (rts_n)
);

// File: tb/uart_frac_top_bench.sv
`timescale 1ns/1ps
module uart_frac_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [15:0] rate_word   = 16'd8192;
    logic [1:0]  parity_mode = 2'b00;
    logic        stop_two    = 1'b0;
    logic        flow_en     = 1'b0;
    logic [7:0]  tx_data     = 8'h00;
    logic        tx_valid    = 1'b0;
    logic        rx_ready    = 1'b0;
    logic        cts_n       = 1'b0;
    logic        rxd_drv     = 1'b1;
    logic        loop_en     = 1'b0;
    logic        tx_ready, rx_valid, rx_perr, rx_ferr, txd, rxd, rts_n;
    logic [7:0]  rx_data;

    assign rxd = loop_en ? txd : rxd_drv;

    int cyc  = 0;
    int nchk = 0;
    int nerr = 0;

    always @(posedge clk) cyc <= cyc + 1;

    uart_frac_top u_uart_frac_top (
        .clk (clk), .rst (rst), .rate_word (rate_word), .parity_mode (parity_mode),
        .stop_two (stop_two), .flow_en (flow_en), .tx_data (tx_data), .tx_valid (tx_valid),
        .tx_ready (tx_ready), .rx_data (rx_data), .rx_valid (rx_valid), .rx_ready (rx_ready),
        .rx_perr (rx_perr), .rx_ferr (rx_ferr), .txd (txd), .rxd (rxd), .rts_n (rts_n),
        .cts_n (cts_n)
    );

    always @(posedge clk) begin
        if (cyc == WATCHDOG) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int bnd(int n, int w);
        return (n * 65536 + w - 1) / w;
    endfunction

    function automatic bit has_p(logic [1:0] m);
        return (m == 2'b01) || (m == 2'b10);
    endfunction

    function automatic logic pbit(logic [7:0] b, logic [1:0] m);
        return (m == 2'b01) ? ~(^b) : (^b);
    endfunction

    function automatic int nbits(logic [1:0] m, logic two);
        return 10 + int'(has_p(m)) + int'(two);
    endfunction

    task automatic tx_put(input logic [7:0] b);
        int to = 0;
        do begin @(negedge clk); to++; end while (!tx_ready && to < 20000);
        tx_data  = b;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic decode(input logic [7:0] b, input string req, output int s);
        logic [11:0] ex;
        logic [11:0] got;
        int n, w, to;
        w  = int'(rate_word);
        n  = nbits(parity_mode, stop_two);
        ex = '1;
        ex[0] = 1'b0;
        ex[8:1] = b;
        if (has_p(parity_mode)) ex[9] = pbit(b, parity_mode);
        got = '1;
        to  = 0;
        do begin @(negedge clk); to++; end while (txd !== 1'b0 && to < 20000);
        s = cyc;
        for (int i = 0; i < n; i++) begin
            int t;
            t = s + (bnd(i, w) + bnd(i + 1, w) - 1) / 2;
            while (cyc < t) @(negedge clk);
            got[i] = txd;
        end
        check(got == ex && to < 20000, req, "txd frame bits", got, ex);
    endtask

    task automatic wait_rx();
        int k = 0;
        while (!rx_valid && k < 400) begin @(negedge clk); k++; end
    endtask

    task automatic release_rx();
        @(negedge clk); rx_ready = 1'b1;
        @(negedge clk); rx_ready = 1'b0;
        check(!rx_valid && !rts_n, "R7", "holding cleared after read", {rx_valid, rts_n}, 0);
    endtask

    task automatic loop_frame(input logic [7:0] b);
        int s;
        fork
            tx_put(b);
            decode(b, "R2", s);
        join
        wait_rx();
        check(rx_valid && rx_data == b, "R7", "loopback byte", {rx_valid, rx_data}, {1'b1, b});
        check(!rx_perr && !rx_ferr, "R10", "no error flags", {rx_perr, rx_ferr}, 0);
        check(rts_n == flow_en, "R11", "rts_n with byte waiting", rts_n, flow_en);
        release_rx();
    endtask

    task automatic drive_frame(input logic [7:0] b, input bit withp, input logic p, input logic stopv);
        logic [10:0] v;
        int n, s, w;
        w = int'(rate_word);
        v = '1;
        v[0] = 1'b0;
        v[8:1] = b;
        if (withp) begin v[9] = p; v[10] = stopv; n = 11; end
        else       begin v[9] = stopv; n = 10; end
        @(negedge clk);
        rxd_drv = v[0];
        s = cyc;
        for (int i = 1; i < n; i++) begin
            while (cyc < s + bnd(i, w)) @(negedge clk);
            rxd_drv = v[i];
        end
        while (cyc < s + bnd(n, w)) @(negedge clk);
        rxd_drv = 1'b1;
    endtask

    task automatic back_to_back(input logic [7:0] a, input logic [7:0] b);
        int s1, s2, d;
        d = bnd(nbits(parity_mode, stop_two), int'(rate_word));
        fork
            begin tx_put(a); tx_put(b); end
            begin decode(a, "R2", s1); decode(b, "R2", s2); end
        join
        check((s2 - s1) >= d && (s2 - s1) <= d + 1, "R4", "start-to-start spacing", s2 - s1, d);
    endtask

    initial begin
        logic [15:0] rates [3];
        logic [7:0]  pats  [4];
        rates[0] = 16'd16384; rates[1] = 16'd8192; rates[2] = 16'd5000;
        pats[0]  = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(txd == 1'b1, "R12", "txd after reset", txd, 1);
        check(!rx_valid, "R12", "rx_valid after reset", rx_valid, 0);
        check(!rts_n, "R12", "rts_n after reset", rts_n, 0);
        check(tx_ready, "R12", "tx_ready after reset", tx_ready, 1);
        flow_en = 1'b1;
        @(negedge clk);
        check(!rts_n, "R11", "rts_n low when empty", rts_n, 0);
        flow_en = 1'b0;

        // R1 R2 R3 R4 R7: loopback sweep over rate, parity and stop settings
        loop_en = 1'b1;
        for (int r = 0; r < 3; r++) begin
            rate_word = rates[r];
            for (int pm = 0; pm < 4; pm++) begin
                for (int st = 0; st < 2; st++) begin
                    parity_mode = 2'(pm);
                    stop_two    = st[0];
                    flow_en     = st[0];
                    for (int k = 0; k < 4; k++) loop_frame(pats[k]);
                end
            end
        end

        // R3 R7: every byte value at one setting
        rate_word = 16'd16384; parity_mode = 2'b10; stop_two = 1'b0; flow_en = 1'b0;
        for (int v = 0; v < 256; v++) loop_frame(8'(v));

        // R1 R4: frame length through start spacing
        loop_en = 1'b0;
        rxd_drv = 1'b1;
        for (int r = 0; r < 3; r++) begin
            rate_word = rates[r];
            for (int pm = 0; pm < 2; pm++) begin
                for (int st = 0; st < 2; st++) begin
                    parity_mode = 2'(pm);
                    stop_two    = st[0];
                    back_to_back(8'h55, 8'hC8);
                end
            end
        end

        // R6: clear input blocks transmission while flow control is on
        rate_word = 16'd8192; parity_mode = 2'b00; stop_two = 1'b0;
        flow_en = 1'b1; cts_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!tx_ready, "R6", "tx_ready while cts_n high", tx_ready, 0);
        begin
            int s;
            fork
                tx_put(8'h5A);
                begin
                    bit low_seen = 1'b0;
                    repeat (60) begin @(negedge clk); if (!txd) low_seen = 1'b1; end
                    check(!low_seen && !tx_ready, "R6", "no start while blocked", {low_seen, tx_ready}, 0);
                    cts_n = 1'b0;
                    decode(8'h5A, "R6", s);
                end
            join
        end
        // R6: cts_n ignored with flow control off
        flow_en = 1'b0; cts_n = 1'b1;
        begin
            int s;
            fork
                tx_put(8'h96);
                decode(8'h96, "R6", s);
            join
        end
        cts_n = 1'b0;

        // R9: stop bit sampled low
        repeat (20) @(negedge clk);
        drive_frame(8'hC3, 1'b0, 1'b0, 1'b0);
        wait_rx();
        check(rx_valid && rx_data == 8'hC3, "R7", "byte with bad stop", rx_data, 8'hC3);
        check(rx_ferr == 1'b1, "R9", "framing flag set", rx_ferr, 1);
        check(rx_perr == 1'b0, "R10", "parity flag clear with parity off", rx_perr, 0);
        release_rx();
        repeat (20) @(negedge clk);

        // R10: even parity, wrong bit
        parity_mode = 2'b10;
        drive_frame(8'h81, 1'b1, 1'b1, 1'b1);
        wait_rx();
        check(rx_valid && rx_data == 8'h81, "R7", "byte with bad even parity", rx_data, 8'h81);
        check(rx_perr == 1'b1 && rx_ferr == 1'b0, "R10", "even parity error", {rx_perr, rx_ferr}, 2'b10);
        release_rx();
        // R10: odd parity, wrong bit then right bit
        parity_mode = 2'b01;
        drive_frame(8'h07, 1'b1, 1'b1, 1'b1);
        wait_rx();
        check(rx_perr == 1'b1, "R10", "odd parity error", rx_perr, 1);
        release_rx();
        drive_frame(8'h07, 1'b1, 1'b0, 1'b1);
        wait_rx();
        check(rx_valid && rx_perr == 1'b0 && rx_ferr == 1'b0, "R10", "odd parity match", {rx_perr, rx_ferr}, 0);
        release_rx();

        // R8: short low pulse is not a start
        parity_mode = 2'b00;
        repeat (10) @(negedge clk);
        rxd_drv = 1'b0;
        @(negedge clk);
        rxd_drv = 1'b1;
        repeat (150) @(negedge clk);
        check(!rx_valid, "R8", "no byte from glitch", rx_valid, 0);
        drive_frame(8'h66, 1'b0, 1'b0, 1'b1);
        wait_rx();
        check(rx_valid && rx_data == 8'h66 && !rx_ferr, "R8", "good byte after glitch",
              {rx_valid, rx_data, rx_ferr}, {1'b1, 8'h66, 1'b0});
        release_rx();

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule